// File: doc/BRIEF.md
# Raster Timing Generator with Blanking Control

This block produces the horizontal sync, vertical sync, blanking and active-area signals for a raster display. It also produces the byte address of the pixel on screen at each moment. The raster runs at one pixel per clock. The horizontal position is counted in units of two pixels. The vertical position is counted in half-line units, so every line adds two. Every edge of sync and blanking comes from sixteen programmable timing registers, which are loaded through a simple write port.

A control word gates each sync output separately and can force the whole display to blank. System software loads new timing while the display is forced blank, then clears the force bit to turn the picture back on. A start-address register places the visible window inside a larger virtual frame, which allows panning. The line pitch register sets the stride from one line to the next. The pixel-format code sets how many bytes each pixel advances the address. A new start address is held in a shadow register and is only taken into use when vertical blanking begins, so a frame never shows two different origins.

All outputs are registered. Each output reflects the raster position one clock after that position is reached.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is high, the outputs are hsync 0, vsync 0, blank 1, active 0 and address 0. Reset returns the control word to 0x400 (forced blank, both syncs off), the pitch, format and start address to 0, and the timing registers to their parameter defaults.
- R2: The line has 2*(hperiod+2) pixels. The horizontal count is the pixel index divided by two, and it wraps after the count hperiod+1. hsync (before gating) is high when the count is at least hssync or below hesync. Timing register indices: 0 hperiod, 1 hssync, 2 hesync, 3 hsblank, 4 heblank.
- R3: Horizontal blanking is in effect when the horizontal count is at least hsblank or below heblank.
- R4: The vertical count is twice the line index and wraps at vperiod. vsync (before gating) is high when the count is at least vssync or below vesync. Vertical blanking is in effect when the count is at least vsblank or below veblank. Timing register indices: 5 vperiod, 6 vssync, 7 vesync, 8 vsblank, 9 veblank. Indices 10 to 15 are extra timing storage.
- R5: The control word is at write address 16. hsync is driven only when bits 5 and 4 are both 1. vsync is driven only when bits 1 and 0 are both 1. Otherwise each sync is held low.
- R6: Control bit 10 forces blank high and active low, whatever the raster position.
- R7: active is high exactly when blank is low.
- R8: During active video, the address is start + L*pitch + (X << fmt). L is the active line index and X is the active pixel index. The pitch is at address 18. The format at address 19 is 0, 1 or 2 for 1, 2 or 4 bytes per pixel.
- R9: The start address is at write address 17. A written value takes effect only on the first line of vertical blanking that follows the write, so the rest of the current frame keeps the old origin.
- R10: The low five bits of a written start address are discarded, so the origin is always 32-byte aligned.
- R11: A write of format code 3 is ignored, and the previous format stays in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | DW | Register write data |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| blank_o | output | 1 | Blanking |
| active_o | output | 1 | Active picture area |
| pix_addr_o | output | AW | Byte address of the current pixel |

## Verification
Several checks hold on every cycle. The assertions cover the gating of each sync by its enable pair, the forced blank, the rule that active and blank exclude each other, the per-pixel address step within a line, the range of the horizontal counter, and the shadow start address changing only at line boundaries. Some behaviours can only be shown by the bench's full-frame sweeps: the exact positions of every sync and blanking edge, the line-by-line address against the pitch, the deferred start address with its alignment, and the rejection of the reserved format code. The bench checks each pixel of twelve frames of a small raster against values it computes arithmetically.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  localparam int NUM_TREG  = 16;
  localparam int RA_W      = 5;
  localparam int CTRL_W    = 11;
  localparam int ALIGN_BITS = 5;

  // timing register indices
  localparam int TI_HPERIOD = 0;
  localparam int TI_HSSYNC  = 1;
  localparam int TI_HESYNC  = 2;
  localparam int TI_HSBLANK = 3;
  localparam int TI_HEBLANK = 4;
  localparam int TI_VPERIOD = 5;
  localparam int TI_VSSYNC  = 6;
  localparam int TI_VESYNC  = 7;
  localparam int TI_VSBLANK = 8;
  localparam int TI_VEBLANK = 9;

  // other register addresses
  localparam logic [RA_W-1:0] RA_CTRL  = 5'd16;
  localparam logic [RA_W-1:0] RA_START = 5'd17;
  localparam logic [RA_W-1:0] RA_PITCH = 5'd18;
  localparam logic [RA_W-1:0] RA_FMT   = 5'd19;

  // control word bit positions
  localparam int CB_VS_LO = 0;
  localparam int CB_HS_LO = 4;
  localparam int CB_BLANK = 10;
  localparam logic [CTRL_W-1:0] CTRL_RST = 11'h400;

  typedef enum logic [1:0] {
    FMT_B1  = 2'd0,
    FMT_B2  = 2'd1,
    FMT_B4  = 2'd2,
    FMT_RSV = 2'd3
  } pix_fmt_e;
endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int TW = 12,
  parameter int AW = 24,
  parameter int DW = 32,
  parameter logic [NUM_TREG*TW-1:0] RST_TIMING = '0
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr_en,
  input  logic [RA_W-1:0]              wr_addr,
  input  logic [DW-1:0]                wr_data,
  output logic [NUM_TREG-1:0][TW-1:0]  timing_q,
  output logic [CTRL_W-1:0]            ctrl_q,
  output logic [AW-1:0]                start_q,
  output logic [AW-1:0]                pitch_q,
  output pix_fmt_e                     fmt_q
);
  logic unused_wdata;
  assign unused_wdata = ^wr_data;

  for (genvar i = 0; i < NUM_TREG; i++) begin : g_treg
    logic [TW-1:0] val_q;
    always_ff @(posedge clk) begin
      if (rst)
        val_q <= RST_TIMING[i*TW +: TW];
      else if (wr_en && wr_addr == RA_W'(i))
        val_q <= wr_data[TW-1:0];
    end
    assign timing_q[i] = val_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= CTRL_RST;
      start_q <= '0;
      pitch_q <= '0;
      fmt_q   <= FMT_B1;
    end else if (wr_en) begin
      case (wr_addr)
        RA_CTRL:  ctrl_q  <= wr_data[CTRL_W-1:0];
        RA_START: start_q <= {wr_data[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
        RA_PITCH: pitch_q <= wr_data[AW-1:0];
        RA_FMT:   if (pix_fmt_e'(wr_data[1:0]) != FMT_RSV)
                    fmt_q <= pix_fmt_e'(wr_data[1:0]);
        default:  ;
      endcase
    end
  end

  // R10
  start_align_chk: assert property (@(posedge clk) disable iff (rst)
    start_q[ALIGN_BITS-1:0] == '0);
endmodule

// File: rtl/rtg_raster.sv
module rtg_raster #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] hperiod,
  input  logic [TW-1:0] hssync,
  input  logic [TW-1:0] hesync,
  input  logic [TW-1:0] hsblank,
  input  logic [TW-1:0] heblank,
  input  logic [TW-1:0] vperiod,
  input  logic [TW-1:0] vssync,
  input  logic [TW-1:0] vesync,
  input  logic [TW-1:0] vsblank,
  input  logic [TW-1:0] veblank,
  output logic          hs_raw,
  output logic          vs_raw,
  output logic          hb_raw,
  output logic          vb_raw,
  output logic          h_act,
  output logic          v_act,
  output logic          line_wrap,
  output logic [TW-1:0] vcnt_next
);
  logic          phase;
  logic [TW-1:0] hcnt;
  logic [TW-1:0] vcnt;
  logic [TW:0]   hlim;
  logic [TW:0]   vsum;

  assign hlim      = {1'b0, hperiod} + (TW+1)'(1);
  assign line_wrap = phase && ({1'b0, hcnt} >= hlim);
  assign vsum      = {1'b0, vcnt} + (TW+1)'(2);
  assign vcnt_next = (vsum >= {1'b0, vperiod}) ? '0 : vsum[TW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= 1'b0;
      hcnt  <= '0;
      vcnt  <= '0;
    end else begin
      phase <= ~phase;
      if (line_wrap) begin
        hcnt <= '0;
        vcnt <= vcnt_next;
      end else if (phase) begin
        hcnt <= hcnt + TW'(1);
      end
    end
  end

  assign hs_raw = (hcnt >= hssync)  || (hcnt < hesync);
  assign hb_raw = (hcnt >= hsblank) || (hcnt < heblank);
  assign vs_raw = (vcnt >= vssync)  || (vcnt < vesync);
  assign vb_raw = (vcnt >= vsblank) || (vcnt < veblank);
  assign h_act  = !hb_raw;
  assign v_act  = !vb_raw;

  // R2
  hcnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    (({1'b0, $past(hcnt)} <= {1'b0, $past(hperiod)} + (TW+1)'(1)) && $stable(hperiod))
      |-> ({1'b0, hcnt} <= hlim));
endmodule

// File: rtl/rtg_addr.sv
module rtg_addr
  import rtg_pkg::*;
#(
  parameter int TW = 12,
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_wrap,
  input  logic          h_act,
  input  logic          v_act,
  input  logic [TW-1:0] vcnt_next,
  input  logic [TW-1:0] vsblank,
  input  logic [TW-1:0] veblank,
  input  logic [AW-1:0] start_q,
  input  logic [AW-1:0] pitch_q,
  input  pix_fmt_e      fmt_q,
  output logic [AW-1:0] pix_addr
);
  logic [AW-1:0] active_start;
  logic [AW-1:0] row_base;
  logic [AW-1:0] px_off;
  logic [AW-1:0] step;

  assign step = AW'(1) << fmt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_start <= '0;
      row_base     <= '0;
      px_off       <= '0;
    end else begin
      if (line_wrap && vcnt_next == vsblank)
        active_start <= start_q;
      if (line_wrap) begin
        px_off <= '0;
        if (vcnt_next == veblank)
          row_base <= active_start;
        else if (v_act)
          row_base <= row_base + pitch_q;
      end else if (h_act) begin
        px_off <= px_off + step;
      end
    end
  end

  assign pix_addr = row_base + px_off;

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(line_wrap) |-> $stable(active_start));
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int TW = 12,
  parameter int AW = 24,
  parameter int DW = 32,
  parameter int H_PERIOD_RST = 398,
  parameter int H_SSYNC_RST  = 399,
  parameter int H_ESYNC_RST  = 47,
  parameter int H_SBLANK_RST = 391,
  parameter int H_EBLANK_RST = 71,
  parameter int V_PERIOD_RST = 1050,
  parameter int V_SSYNC_RST  = 1048,
  parameter int V_ESYNC_RST  = 2,
  parameter int V_SBLANK_RST = 1028,
  parameter int V_EBLANK_RST = 68
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [RA_W-1:0] wr_addr,
  input  logic [DW-1:0]   wr_data,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            blank_o,
  output logic            active_o,
  output logic [AW-1:0]   pix_addr_o
);
  localparam int AUX_N = NUM_TREG - 10;
  localparam logic [NUM_TREG*TW-1:0] RST_TIMING = {
    {(AUX_N*TW){1'b0}},
    TW'(V_EBLANK_RST), TW'(V_SBLANK_RST), TW'(V_ESYNC_RST),
    TW'(V_SSYNC_RST),  TW'(V_PERIOD_RST),
    TW'(H_EBLANK_RST), TW'(H_SBLANK_RST), TW'(H_ESYNC_RST),
    TW'(H_SSYNC_RST),  TW'(H_PERIOD_RST)
  };

  logic [NUM_TREG-1:0][TW-1:0] timing_q;
  logic [CTRL_W-1:0]           ctrl_q;
  logic [AW-1:0]               start_q;
  logic [AW-1:0]               pitch_q;
  pix_fmt_e                    fmt_q;

  logic hs_raw, vs_raw, hb_raw, vb_raw, h_act, v_act, line_wrap;
  logic [TW-1:0] vcnt_next;
  logic [AW-1:0] pix_addr;
  logic hs_en, vs_en, force_blank;
  logic unused_bits;

  assign unused_bits = ^{ctrl_q[9:6], ctrl_q[3:2], timing_q[NUM_TREG-1:10]};

  rtg_regs #(.TW(TW), .AW(AW), .DW(DW), .RST_TIMING(RST_TIMING)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .timing_q(timing_q), .ctrl_q(ctrl_q), .start_q(start_q),
    .pitch_q(pitch_q), .fmt_q(fmt_q)
  );

  rtg_raster #(.TW(TW)) u_raster (
    .clk(clk), .rst(rst),
    .hperiod(timing_q[TI_HPERIOD]), .hssync(timing_q[TI_HSSYNC]),
    .hesync(timing_q[TI_HESYNC]),   .hsblank(timing_q[TI_HSBLANK]),
    .heblank(timing_q[TI_HEBLANK]), .vperiod(timing_q[TI_VPERIOD]),
    .vssync(timing_q[TI_VSSYNC]),   .vesync(timing_q[TI_VESYNC]),
    .vsblank(timing_q[TI_VSBLANK]), .veblank(timing_q[TI_VEBLANK]),
    .hs_raw(hs_raw), .vs_raw(vs_raw), .hb_raw(hb_raw), .vb_raw(vb_raw),
    .h_act(h_act), .v_act(v_act), .line_wrap(line_wrap), .vcnt_next(vcnt_next)
  );

  rtg_addr #(.TW(TW), .AW(AW)) u_addr (
    .clk(clk), .rst(rst), .line_wrap(line_wrap), .h_act(h_act), .v_act(v_act),
    .vcnt_next(vcnt_next), .vsblank(timing_q[TI_VSBLANK]),
    .veblank(timing_q[TI_VEBLANK]), .start_q(start_q), .pitch_q(pitch_q),
    .fmt_q(fmt_q), .pix_addr(pix_addr)
  );

  assign hs_en       = &ctrl_q[CB_HS_LO+1:CB_HS_LO];
  assign vs_en       = &ctrl_q[CB_VS_LO+1:CB_VS_LO];
  assign force_blank = ctrl_q[CB_BLANK];

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o    <= 1'b0;
      vsync_o    <= 1'b0;
      blank_o    <= 1'b1;
      active_o   <= 1'b0;
      pix_addr_o <= '0;
    end else begin
      hsync_o    <= hs_raw & hs_en;
      vsync_o    <= vs_raw & vs_en;
      blank_o    <= hb_raw | vb_raw | force_blank;
      active_o   <= h_act & v_act & ~force_blank;
      pix_addr_o <= pix_addr;
    end
  end

  // R5
  hsync_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_q[CB_HS_LO+1:CB_HS_LO]) != 2'b11) |-> !hsync_o);
  // R5
  vsync_gate_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ctrl_q[CB_VS_LO+1:CB_VS_LO]) != 2'b11) |-> !vsync_o);
  // R6
  blank_force_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ctrl_q[CB_BLANK]) |-> (blank_o && !active_o));
  // R7
  active_excl_chk: assert property (@(posedge clk) disable iff (rst)
    active_o |-> !blank_o);
  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (active_o && $past(active_o) && fmt_q == $past(fmt_q) && $past(fmt_q) == $past(fmt_q, 2))
      |-> (pix_addr_o == $past(pix_addr_o) + (AW'(1) << fmt_q)));
endmodule

// File: tb/tb_raster_timing_gen.sv
`timescale 1ns/1ps
module tb_raster_timing_gen;
  localparam int TW = 8;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int LPIX = 28;
  localparam int NLINE = 9;
  localparam int FRM = LPIX * NLINE;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic hsync_o, vsync_o, blank_o, active_o;
  logic [AW-1:0] pix_addr_o;

  raster_timing_gen #(
    .TW(TW), .AW(AW), .DW(DW),
    .H_PERIOD_RST(12), .H_SSYNC_RST(13), .H_ESYNC_RST(2),
    .H_SBLANK_RST(12), .H_EBLANK_RST(4),
    .V_PERIOD_RST(18), .V_SSYNC_RST(16), .V_ESYNC_RST(2),
    .V_SBLANK_RST(14), .V_EBLANK_RST(6)
  ) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o),
    .active_o(active_o), .pix_addr_o(pix_addr_o)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int k = 0;
  int last_wr_k = -10;
  bit chk_on = 1'b0;
  bit done = 1'b0;
  logic [10:0] ctrl_m = 11'h400;
  int pitch_m = 0;
  int fmt_m = 0;
  int start_m = 0;
  int shadow_m = 0;

  always @(posedge clk) begin
    if (rst) k <= 0;
    else k <= k + 1;
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, k);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (k % FRM == 196) shadow_m = start_m;
      if (chk_on && k > last_wr_k + 1 && k >= 1) begin
        int idx, p, ln, frame;
        bit hs_e, vs_e, hb_e, vb_e, bl_e;
        int a_e;
        string atag;
        idx = k - 1;
        p = idx % LPIX;
        ln = (idx / LPIX) % NLINE;
        frame = idx / FRM;
        hs_e = (p >= 26 || p < 4) && (ctrl_m[5:4] == 2'b11);
        vs_e = (ln >= 8 || ln < 1) && (ctrl_m[1:0] == 2'b11);
        hb_e = (p >= 24 || p < 8);
        vb_e = (ln >= 7 || ln < 3);
        bl_e = hb_e || vb_e || ctrl_m[10];
        chk(hsync_o == hs_e, (ctrl_m[5:4] == 2'b11) ? "R2" : "R5", "hsync", hsync_o, hs_e);
        chk(vsync_o == vs_e, (ctrl_m[1:0] == 2'b11) ? "R4" : "R5", "vsync", vsync_o, vs_e);
        chk(blank_o == bl_e, ctrl_m[10] ? "R6" : (vb_e ? "R4" : "R3"), "blank", blank_o, bl_e);
        chk(active_o == !bl_e, "R7", "active", active_o, !bl_e);
        if (!bl_e) begin
          a_e = (shadow_m + (ln - 3) * pitch_m + ((p - 8) << fmt_m)) & 16'hFFFF;
          if (frame == 3 || frame == 4) atag = "R9";
          else if (frame == 6) atag = "R10";
          else if (frame == 7) atag = "R11";
          else atag = "R8";
          chk(int'(pix_addr_o) == a_e, atag, "address", pix_addr_o, a_e);
        end
      end
    end
  end

  task automatic upto(input int t);
    while (k < t) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wr(input logic [4:0] a, input int d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
    last_wr_k = k;
    case (a)
      5'd16: ctrl_m = d[10:0];
      5'd17: start_m = d & 32'hFFE0;
      5'd18: pitch_m = d;
      5'd19: if (d[1:0] != 2'd3) fmt_m = d[1:0];
      default: ;
    endcase
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    chk(hsync_o == 1'b0, "R1", "hsync in reset", hsync_o, 0);
    chk(vsync_o == 1'b0, "R1", "vsync in reset", vsync_o, 0);
    chk(blank_o == 1'b1, "R1", "blank in reset", blank_o, 1);
    chk(active_o == 1'b0, "R1", "active in reset", active_o, 0);
    chk(pix_addr_o == '0, "R1", "address in reset", pix_addr_o, 0);
    rst = 1'b0;
    chk_on = 1'b1;
    // frames 0..1 run with reset control: forced blank, syncs off (R1, R5, R6)
    upto(FRM + 8);
    wr(5'd18, 64);
    wr(5'd19, 0);
    wr(5'd16, 32'h033);
    // R9: start written mid-active of frame 3, used from frame 4
    upto(3 * FRM + 120);
    wr(5'd17, 32'h1000);
    // R8: 2 bytes per pixel
    upto(5 * FRM + 10);
    wr(5'd19, 1);
    wr(5'd18, 128);
    // R10: unaligned start, used from frame 6
    upto(5 * FRM + 150);
    wr(5'd17, 32'h2013);
    // R8: 4 bytes per pixel
    upto(6 * FRM + 10);
    wr(5'd19, 2);
    wr(5'd18, 256);
    // R11: reserved format code ignored
    upto(7 * FRM + 10);
    wr(5'd19, 3);
    // R5: hsync disabled
    upto(8 * FRM + 10);
    wr(5'd16, 32'h003);
    // R5: vsync partially enabled counts as disabled
    upto(9 * FRM + 10);
    wr(5'd16, 32'h031);
    // R6: forced blank with syncs on
    upto(10 * FRM + 10);
    wr(5'd16, 32'h433);
    // display back on
    upto(11 * FRM + 10);
    wr(5'd16, 32'h033);
    upto(12 * FRM + 2);
    chk_on = 1'b0;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule